// File: doc/BRIEF.md
# Modbus RTU Read-Response Frame Generator

This block builds the reply to a read request on a multidrop serial bus that uses the Modbus RTU binary framing. An upstream decoder hands it a request that has already been checked: the slave address, the function code to echo, a start offset into the register file, a count and a format flag. The block waits out a quiet-line interval, then offers the reply one byte at a time to a UART transmitter through a valid/ready handshake, so the UART sets the pace.

The register words come from an external synchronous register file with one cycle of read latency. The format flag selects one of two banks. With the flag low, each requested register is one 16-bit scaled integer. With the flag high, the count names single-precision float values, and each value takes two consecutive 16-bit registers, the more significant half first. The CRC-16 is folded in as each byte leaves, so the frame is never walked a second time. The node only ever replies to a request: while a reply is in progress it reports busy and ignores new requests.

Top module: `rtu_resp_gen`

## Requirements
- R1: After synchronous active-low reset, busy, tx_valid and rf_rd_en are all low.
- R2: A request is accepted on the edge where req_valid is high and busy is low. tx_valid then stays low for exactly GAP_CYCLES cycles and rises in the cycle after those.
- R3: Frame byte 0 is the latched slave address and byte 1 is the latched function code.
- R4: Frame byte 2 is the data byte count: 2×N in integer mode and 4×N in float mode, where N is req_count.
- R5: In integer mode, N words follow byte 2. Word k is read from rf_rd_addr = {0, (start + k) mod 2^RF_AW} and sent high byte first.
- R6: In float mode, 2×N words follow byte 2. They are read from {1, (start + k) mod 2^RF_AW} for k = 0 … 2N−1. The even word of each pair is the more significant half of the value and is sent first, high byte first within each word.
- R7: The last two bytes are the CRC-16 over all earlier bytes of the frame, low byte first. The CRC starts from 0xFFFF and uses the reflected polynomial 0xA001.
- R8: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change on the next cycle.
- R9: busy is high from the accepting edge until the handshake of the final CRC byte. A request presented while busy is dropped: the frame in progress is unchanged and no second frame follows.
- R10: tx_valid is never high while busy is low, so the block starts no traffic of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Validated read request present |
| req_slave | input | 8 | Slave address to echo |
| req_func | input | 8 | Function code to echo |
| req_start | input | RF_AW | Start offset into the register bank |
| req_count | input | CNT_W | Register count (integer) or value count (float) |
| req_float | input | 1 | 1 = float format, 0 = scaled integer |
| busy | output | 1 | Reply in progress |
| rf_rd_en | output | 1 | Register file read strobe |
| rf_rd_addr | output | RF_AW+1 | {bank, offset} read address |
| rf_rd_data | input | 16 | Read data, one cycle after rf_rd_en |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte offered |
| tx_ready | input | 1 | Transmitter takes the byte |

## Verification
Two things can happen in the same clock cycle: the transmitter stalling on a byte, which must hold that byte and its CRC contribution, and the hand-off that both updates the CRC and advances the frame. The bench runs every count in both formats at several start offsets, and each run uses a continuous, alternating or two-in-three ready pattern. This places stalls on header, data and CRC bytes. Each captured frame is compared byte by byte with an expected frame built from the bench's register model and its own CRC. A second coincidence is a new request that lands while a reply is in flight. The bench provokes it in the middle of the data and judges it by the unchanged frame and a silent line afterwards.

// File: rtl/rtu_pkg.sv
// Shared types and the CRC step for the RTU reply generator.
// Assumes reflected CRC-16 with preset 0xFFFF and polynomial 0xA001.
package rtu_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GAP,
        S_HDR,
        S_FETCH,
        S_LATCH,
        S_DHI,
        S_DLO,
        S_CRCL,
        S_CRCH
    } rsp_state_t;

    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY   = 16'hA001;

    // Fold one byte into a CRC value, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rtu_gap_timer.sv
// Quiet-line timer: counts the cycles spent in the gap state.
// Assumes clear is held high whenever the gap is not being timed.
// expired is high in the cycle in which GAP_CYCLES cycles have elapsed.
module rtu_gap_timer #(
    parameter int GAP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(GAP_CYCLES - 1));

    // Count up while timing, saturating at the expiry value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtu_crc16.sv
// Running CRC-16 register for the outgoing frame.
// Assumes init is asserted before the first byte and upd only on a byte hand-off.
module rtu_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  byte_in,
    output logic [15:0] crc
);
    import rtu_pkg::*;

    // Preset on init, fold the handed-off byte on upd.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc <= CRC_PRESET;
        end else if (upd) begin
            crc <= crc16_step(crc, byte_in);
        end
    end

endmodule

// File: rtl/rtu_byte_sel.sv
// Output byte selector: picks the byte the current state offers.
// Assumes the header index runs 0..2 and the CRC holds its final value in the CRC states.
module rtu_byte_sel (
    input  rtu_pkg::rsp_state_t state,
    input  logic [1:0]          hdr_idx,
    input  logic [7:0]          slave,
    input  logic [7:0]          func,
    input  logic [7:0]          bcount,
    input  logic [15:0]         word_q,
    input  logic [15:0]         crc,
    output logic                valid_o,
    output logic [7:0]          byte_o
);
    import rtu_pkg::*;

    // Map the state to the offered byte and its valid flag.
    always_comb begin
        valid_o = 1'b1;
        byte_o  = 8'h00;
        case (state)
            S_HDR: begin
                case (hdr_idx)
                    2'd0:    byte_o = slave;
                    2'd1:    byte_o = func;
                    default: byte_o = bcount;
                endcase
            end
            S_DHI:   byte_o = word_q[15:8];
            S_DLO:   byte_o = word_q[7:0];
            S_CRCL:  byte_o = crc[7:0];
            S_CRCH:  byte_o = crc[15:8];
            default: valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtu_resp_gen.sv
// RTU read-response frame generator (top).
// Takes one validated read request, waits GAP_CYCLES quiet cycles, then
// streams address, function, byte count, register data and CRC-16 to a
// valid/ready byte sink. Assumes req_count is 1..16 in integer mode and
// 1..8 in float mode, and that rf_rd_data is valid one cycle after rf_rd_en.
module rtu_resp_gen #(
    parameter int RF_AW      = 5,
    parameter int CNT_W      = 5,
    parameter int GAP_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_slave,
    input  logic [7:0]       req_func,
    input  logic [RF_AW-1:0] req_start,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_float,
    output logic             busy,
    output logic             rf_rd_en,
    output logic [RF_AW:0]   rf_rd_addr,
    input  logic [15:0]      rf_rd_data,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready
);
    import rtu_pkg::*;

    localparam int WD_W = CNT_W + 1;

    rsp_state_t       state;
    logic [1:0]       hdr_idx;
    logic [WD_W-1:0]  word_idx;
    logic [15:0]      word_q;
    logic [7:0]       lat_slave;
    logic [7:0]       lat_func;
    logic [RF_AW-1:0] lat_start;
    logic [CNT_W-1:0] lat_count;
    logic             lat_float;

    logic [WD_W-1:0]  words;
    logic [7:0]       bcount;
    logic             last_word;
    logic             fire;
    logic             gap_expired;
    logic [15:0]      crc;
    logic             crc_upd;

    assign words     = lat_float ? {lat_count, 1'b0} : {1'b0, lat_count};
    assign bcount    = 8'({words, 1'b0});
    assign last_word = (word_idx == words - 1'b1);
    assign fire      = tx_valid && tx_ready;
    assign busy      = (state != S_IDLE);
    assign rf_rd_en  = (state == S_FETCH);
    assign rf_rd_addr = {lat_float, lat_start + RF_AW'(word_idx)};
    assign crc_upd   = fire && (state == S_HDR || state == S_DHI || state == S_DLO);

    rtu_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state != S_GAP),
        .expired (gap_expired)
    );

    rtu_crc16 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (state == S_GAP),
        .upd     (crc_upd),
        .byte_in (tx_data),
        .crc     (crc)
    );

    rtu_byte_sel u_sel (
        .state   (state),
        .hdr_idx (hdr_idx),
        .slave   (lat_slave),
        .func    (lat_func),
        .bcount  (bcount),
        .word_q  (word_q),
        .crc     (crc),
        .valid_o (tx_valid),
        .byte_o  (tx_data)
    );

    // Capture the request only when idle; requests arriving while busy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_slave <= '0;
            lat_func  <= '0;
            lat_start <= '0;
            lat_count <= '0;
            lat_float <= 1'b0;
        end else if (state == S_IDLE && req_valid) begin
            lat_slave <= req_slave;
            lat_func  <= req_func;
            lat_start <= req_start;
            lat_count <= req_count;
            lat_float <= req_float;
        end
    end

    // Frame sequencer: gap, header, fetch/latch/send per word, CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            hdr_idx  <= '0;
            word_idx <= '0;
            word_q   <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) state <= S_GAP;
                S_GAP: begin
                    hdr_idx <= '0;
                    if (gap_expired) state <= S_HDR;
                end
                S_HDR: if (fire) begin
                    if (hdr_idx == 2'd2) begin
                        word_idx <= '0;
                        state    <= S_FETCH;
                    end else begin
                        hdr_idx <= hdr_idx + 1'b1;
                    end
                end
                S_FETCH: state <= S_LATCH;
                S_LATCH: begin
                    word_q <= rf_rd_data;
                    state  <= S_DHI;
                end
                S_DHI: if (fire) state <= S_DLO;
                S_DLO: if (fire) begin
                    if (last_word) begin
                        state <= S_CRCL;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                        state    <= S_FETCH;
                    end
                end
                S_CRCL: if (fire) state <= S_CRCH;
                S_CRCH: if (fire) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: the first header byte is only reached once the quiet interval has expired.
    a_r2_gap_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR && $past(state) == S_GAP) |-> $past(gap_expired));

    // R8: a stalled byte is held unchanged.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10: nothing is offered while idle.
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid);

    // R9: a request seen while busy leaves the latched request untouched.
    a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(lat_slave) && $stable(lat_count) && $stable(lat_float)));

    // R5: each register read is a single-cycle strobe followed by a latch cycle.
    a_r5_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |=> !rf_rd_en);

    // R7: the CRC register is frozen while its own bytes are sent.
    a_r7_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CRCL || state == S_CRCH) |=> $stable(crc));

endmodule

// File: tb/rtu_resp_gen_bench.sv
// Sweep bench for rtu_resp_gen: all counts in both formats, several
// start offsets and ready patterns; expected frames built from a bench model.
module rtu_resp_gen_bench;

    localparam int RF_AW = 5;
    localparam int CNT_W = 5;
    localparam int GAP   = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [7:0]       req_slave = '0;
    logic [7:0]       req_func = '0;
    logic [RF_AW-1:0] req_start = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic             req_float = 1'b0;
    logic             busy;
    logic             rf_rd_en;
    logic [RF_AW:0]   rf_rd_addr;
    logic [15:0]      rf_q = '0;
    logic             tx_valid;
    logic [7:0]       tx_data;
    logic             tx_ready = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rtu_resp_gen #(.RF_AW(RF_AW), .CNT_W(CNT_W), .GAP_CYCLES(GAP)) u_rtu_resp_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slave(req_slave),
        .req_func(req_func), .req_start(req_start), .req_count(req_count),
        .req_float(req_float), .busy(busy), .rf_rd_en(rf_rd_en),
        .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_q), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready)
    );

    function automatic logic [15:0] rf_val(input logic [RF_AW:0] a);
        logic [15:0] p;
        p = {10'd0, a} * 16'd4099;
        return p ^ 16'h5AC3;
    endfunction

    function automatic logic [15:0] crc_bytewise(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 16'hA001;
            else r = r >> 1;
        end
        return r;
    endfunction

    // Synchronous register-file model, one cycle of latency.
    always_ff @(posedge clk) begin
        if (rf_rd_en) rf_q <= rf_val(rf_rd_addr);
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] slv, input logic [7:0] fn,
                             input int start, input int cnt, input bit flt,
                             input int bp, input bit inject);
        logic [7:0] exp_b [0:39];
        logic [7:0] got_b [0:39];
        int words, len, ngot, zeros, stall_bad, busy_bad, t;
        bit seen, prev_v, prev_r, rdy, injected;
        logic [7:0] prev_d;
        logic [15:0] c, w;
        logic [RF_AW:0] a;
        bit hdr_ok, data_ok, crc_ok;

        words = flt ? 2 * cnt : cnt;
        len = 3 + 2 * words + 2;
        exp_b[0] = slv;
        exp_b[1] = fn;
        exp_b[2] = 8'(2 * words);
        for (int k = 0; k < words; k++) begin
            a = {flt, RF_AW'(start + k)};
            w = rf_val(a);
            exp_b[3 + 2 * k] = w[15:8];
            exp_b[4 + 2 * k] = w[7:0];
        end
        c = 16'hFFFF;
        for (int i = 0; i < len - 2; i++) c = crc_bytewise(c, exp_b[i]);
        exp_b[len - 2] = c[7:0];
        exp_b[len - 1] = c[15:8];

        req_slave = slv; req_func = fn; req_start = RF_AW'(start);
        req_count = CNT_W'(cnt); req_float = flt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ngot = 0; zeros = 0; seen = 0; stall_bad = 0; busy_bad = 0;
        prev_v = 0; prev_r = 0; prev_d = '0; t = 0; injected = 0;
        while (ngot < len && t < 3000) begin
            case (bp)
                0: rdy = 1'b1;
                1: rdy = (t % 2) == 1;
                default: rdy = (t % 3) != 0;
            endcase
            tx_ready = rdy;
            if (!busy) busy_bad++;
            if (prev_v && !prev_r && (!tx_valid || tx_data != prev_d)) stall_bad++;
            if (!tx_valid && !seen) zeros++;
            if (tx_valid) seen = 1;
            if (tx_valid && rdy) begin
                got_b[ngot] = tx_data;
                ngot++;
            end
            if (inject && !injected && ngot == 5) begin
                req_valid = 1'b1; req_slave = 8'h5A; req_count = CNT_W'(1);
                injected = 1;
            end else begin
                req_valid = 1'b0;
            end
            prev_v = tx_valid; prev_r = rdy; prev_d = tx_data;
            t++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        tx_ready = 1'b0;

        check(ngot == len, "R5", "frame length", ngot, len);
        check(zeros == GAP, "R2", "quiet cycles before first byte", zeros, GAP);
        hdr_ok = (got_b[0] == exp_b[0]) && (got_b[1] == exp_b[1]);
        check(hdr_ok, "R3", "address/function", {got_b[0], got_b[1]}, {exp_b[0], exp_b[1]});
        check(got_b[2] == exp_b[2], "R4", "byte count", got_b[2], exp_b[2]);
        data_ok = 1;
        for (int i = 3; i < len - 2; i++) begin
            if (got_b[i] != exp_b[i]) begin
                data_ok = 0;
                check(0, flt ? "R6" : "R5", $sformatf("data byte %0d", i), got_b[i], exp_b[i]);
            end
        end
        if (data_ok) check(1, flt ? "R6" : "R5", "data", 0, 0);
        crc_ok = (got_b[len - 2] == exp_b[len - 2]) && (got_b[len - 1] == exp_b[len - 1]);
        check(crc_ok, "R7", "crc", {got_b[len - 1], got_b[len - 2]}, {exp_b[len - 1], exp_b[len - 2]});
        if (bp != 0) check(stall_bad == 0, "R8", "stalled byte changed", stall_bad, 0);
        check(busy_bad == 0, "R9", "busy low during frame", busy_bad, 0);

        // After the last hand-off the line must go quiet and busy must drop (R9, R10).
        tx_ready = 1'b1;
        busy_bad = 0; stall_bad = 0;
        for (int i = 0; i < GAP + 8; i++) begin
            if (busy) busy_bad++;
            if (tx_valid) stall_bad++;
            @(negedge clk);
        end
        tx_ready = 1'b0;
        check(busy_bad == 0, "R9", "busy after frame", busy_bad, 0);
        check(stall_bad == 0, "R10", "bytes offered while idle", stall_bad, 0);
    endtask

    initial begin
        int starts [3];
        starts[0] = 0; starts[1] = 13; starts[2] = 27;
        repeat (3) @(negedge clk);
        check(!busy && !tx_valid && !rf_rd_en, "R1", "reset outputs",
              {busy, tx_valid, rf_rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !tx_valid, "R1", "idle after reset", {busy, tx_valid}, 0);
        for (int f = 0; f < 2; f++) begin
            for (int n = 1; n <= (f == 1 ? 8 : 16); n++) begin
                for (int s = 0; s < 3; s++) begin
                    run_frame(8'(n + 1), (n % 2) ? 8'h04 : 8'h03, starts[s], n, f[0],
                              (n + s) % 3, 1'b0);
                end
            end
        end
        // R9: requests injected mid-frame are dropped.
        run_frame(8'h07, 8'h04, 5, 4, 1'b0, 1, 1'b1);
        run_frame(8'h10, 8'h03, 30, 8, 1'b1, 2, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule